// File: doc/BRIEF.md
# LED Driver Serial Frame Formatter

This block assembles the serial frames that feed a chain of constant-current LED drivers. Every frame opens with a 24-bit header: a fixed synchronisation byte, a 6-bit command code and a 10-bit running frame number. A payload follows. For a PWM frame, the payload is built from eight 24-bit RGB pixels. Each 8-bit colour is stretched to a 12-bit PWM value, and the values are sent grouped by colour, not pixel by pixel. For a calibration, brightness or configuration frame, the caller supplies the payload bits directly.

The caller presents the pixels or raw bits, a frame kind and a one-cycle start request. The formatter then drives a serial clock, a data line and a load strobe until the frame is finished. A busy flag covers the whole frame, and start requests that arrive while busy are dropped. The pixel width, the 12-bit depth and the header layout are format constants. The number of pixels per frame is a parameter, with a default of 8.

Top module: `led_frame_fmt`

## Requirements
- R1: After reset, ser_clk, ser_dat, ser_load and busy are all low, and the first frame sent carries frame number 0.
- R2: The header is the first 24 bits of each frame and is sent MSB first. It is the byte 8'b11101000, then the 6-bit command, then the 10-bit frame number.
- R3: The kind input selects the command code: 0 gives 000000 (PWM data), 1 gives 010101 (calibration current), 2 gives 101010 (global brightness), 3 gives 111111 (configuration).
- R4: Each 8-bit colour c becomes the 12-bit value {c, c[7:4]}, so 0x00 maps to 0x000 and 0xFF maps to 0xFFF.
- R5: Pixel i occupies px_data[24*i+23 : 24*i], with red in bits 23:16, green in 15:8 and blue in 7:0. A PWM payload sends the blue values of pixels 7 down to 0, then the green values of 7 down to 0, then the red values of 7 down to 0. Each value is 12 bits, MSB first.
- R6: For kinds 1 to 3, the payload is raw_data, sent from bit 287 down to bit 0, and px_data is ignored.
- R7: Each frame holds exactly 312 bits. A bit is put on ser_dat while ser_clk is low. ser_clk rises one cycle later, and ser_dat holds while ser_clk is high. Consecutive rising edges are two cycles apart.
- R8: ser_load is high for exactly one cycle, the cycle after the last high phase of ser_clk, and ser_clk is low during that cycle.
- R9: busy rises in the cycle after an accepted start, stays high through the load cycle and falls in the cycle after it.
- R10: The frame number advances by one after every frame and wraps from 1023 to 0.
- R11: A start request while busy is ignored. The current frame continues unchanged, no second frame follows, and the frame number advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request, taken only when idle |
| kind | input | 2 | Frame kind: 0 PWM, 1 calibration, 2 brightness, 3 configuration |
| px_data | input | 24*NUM_PIX | RGB pixels for a PWM frame, captured at start |
| raw_data | input | 36*NUM_PIX | Payload bits for non-PWM frames, captured at start |
| busy | output | 1 | High from the cycle after start until the load cycle ends |
| ser_clk | output | 1 | Serial clock, one rising edge per bit |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_load | output | 1 | Latch strobe after the last bit |

## Verification
The start edge that accepts a frame also makes busy and the first header bit visible. ser_clk rises one cycle after each bit appears, and bit k (counting from 0) is captured at the ser_clk rise that follows clock edge 2k+1 after start. The load strobe appears 624 edges after the start edge, and busy falls one edge after that. The bench samples on the falling clock edge, half a period after every change. It collects bits only on ser_clk rises that it detects itself, checks the two-cycle spacing of those rises, and compares the full frame at the load strobe with a frame it builds itself. A second instance, with one pixel per frame, sends more than 1024 short frames to show the frame-number wrap within the cycle budget.

// File: rtl/led_fmt_pkg.sv
package led_fmt_pkg;

  localparam int COLOR_W = 8;
  localparam int PWM_W   = 12;
  localparam int CMD_W   = 6;
  localparam int CNT_W   = 10;
  localparam int HDR_W   = 8 + CMD_W + CNT_W;
  localparam int PIX_W   = 3 * COLOR_W;
  localparam logic [7:0] SYNC_BYTE = 8'b1110_1000;

  typedef enum logic [1:0] {
    KIND_PWM = 2'd0,
    KIND_CAL = 2'd1,
    KIND_BRT = 2'd2,
    KIND_CFG = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } eng_state_e;

  function automatic logic [CMD_W-1:0] kind_code(frame_kind_e k);
    logic [CMD_W-1:0] code;
    case (k)
      KIND_PWM: code = 6'b000000;
      KIND_CAL: code = 6'b010101;
      KIND_BRT: code = 6'b101010;
      default:  code = 6'b111111;
    endcase
    return code;
  endfunction

  function automatic logic [PWM_W-1:0] widen(logic [COLOR_W-1:0] c);
    return {c, c[COLOR_W-1 -: PWM_W-COLOR_W]};
  endfunction

  function automatic logic [HDR_W-1:0] make_header(logic [CMD_W-1:0] code,
                                                   logic [CNT_W-1:0] cnt);
    return {SYNC_BYTE, code, cnt};
  endfunction

endpackage

// File: rtl/led_payload_pack.sv
module led_payload_pack
  import led_fmt_pkg::*;
#(
  parameter int NUM_PIX = 8,
  localparam int IN_W   = NUM_PIX * PIX_W,
  localparam int NCH    = 3 * NUM_PIX,
  localparam int OUT_W  = NCH * PWM_W
) (
  input  logic [IN_W-1:0]  px,
  output logic [OUT_W-1:0] payload
);

  // Slot k counted from the MSB end: colour group k / NUM_PIX (blue, green, red),
  // pixel NUM_PIX-1 - (k % NUM_PIX).
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    localparam int GRP = k / NUM_PIX;
    localparam int PIX = NUM_PIX - 1 - (k % NUM_PIX);
    localparam int SRC = PIX * PIX_W + GRP * COLOR_W;
    localparam int DST = OUT_W - 1 - k * PWM_W;
    assign payload[DST -: PWM_W] = widen(px[SRC +: COLOR_W]);
  end

endmodule

// File: rtl/led_frame_cnt.sv
module led_frame_cnt
  import led_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/led_shift_engine.sv
module led_shift_engine
  import led_fmt_pkg::*;
#(
  parameter int FRAME_W = 312,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               busy,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic               ser_load,
  output logic               frame_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  eng_state_e         state;
  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   bit_idx;
  logic               phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      phase   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            shreg   <= frame_in;
            bit_idx <= '0;
            phase   <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bit_idx == LAST_IDX) begin
              state <= ST_LOAD;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign ser_clk    = phase;
  assign ser_dat    = (state == ST_SHIFT) & shreg[FRAME_W-1];
  assign ser_load   = (state == ST_LOAD);
  assign frame_done = (state == ST_LOAD);

endmodule

// File: rtl/led_frame_fmt.sv
module led_frame_fmt
  import led_fmt_pkg::*;
#(
  parameter int NUM_PIX = 8,
  localparam int PX_W    = NUM_PIX * PIX_W,
  localparam int PAY_W   = 3 * NUM_PIX * PWM_W,
  localparam int FRAME_W = HDR_W + PAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [PX_W-1:0]  px_data,
  input  logic [PAY_W-1:0] raw_data,
  output logic             busy,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             ser_load
);

  frame_kind_e        kind_e;
  logic [PAY_W-1:0]   pwm_payload;
  logic [PAY_W-1:0]   sel_payload;
  logic [HDR_W-1:0]   header;
  logic [CNT_W-1:0]   frame_cnt;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_done;
  logic               accept;

  assign kind_e      = frame_kind_e'(kind);
  assign sel_payload = (kind_e == KIND_PWM) ? pwm_payload : raw_data;
  assign header      = make_header(kind_code(kind_e), frame_cnt);
  assign frame_word  = {header, sel_payload};
  assign accept      = start & ~busy;

  led_payload_pack #(.NUM_PIX(NUM_PIX)) i_pack (
    .px      (px_data),
    .payload (pwm_payload)
  );

  led_frame_cnt i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_done),
    .count (frame_cnt)
  );

  led_shift_engine #(.FRAME_W(FRAME_W)) i_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .frame_in   (frame_word),
    .busy       (busy),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .ser_load   (ser_load),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/led_frame_fmt_chk.sv
module led_frame_fmt_chk
  import led_fmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             ser_clk,
  input logic             ser_dat,
  input logic             ser_load,
  input logic             frame_done,
  input logic [CNT_W-1:0] frame_cnt
);

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> !ser_load); // R8
  AST_LOAD_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> !ser_clk); // R8
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> !busy); // R9
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ser_load) |=> busy); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_load && !ser_dat)); // R7
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dat)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (frame_cnt == $past(frame_cnt) + 1'b1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(frame_cnt)); // R10

endmodule

bind led_frame_fmt led_frame_fmt_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .ser_clk    (ser_clk),
  .ser_dat    (ser_dat),
  .ser_load   (ser_load),
  .frame_done (frame_done),
  .frame_cnt  (frame_cnt)
);

// File: tb/test_led_frame_fmt.sv
module test_led_frame_fmt;

  localparam int FW = 312;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         start = 1'b0;
  logic [1:0]   kind = 2'd0;
  logic [191:0] px = '0;
  logic [287:0] raw = '0;
  logic         busy, ser_clk, ser_dat, ser_load;

  logic         w_start = 1'b0;
  logic         w_busy, w_clk, w_dat, w_load;

  led_frame_fmt i_led_frame_fmt (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .px_data(px),
    .raw_data(raw), .busy(busy), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load)
  );

  led_frame_fmt #(.NUM_PIX(1)) i_wrap (
    .clk(clk), .rst_n(rst_n), .start(w_start), .kind(2'd0), .px_data(24'h0),
    .raw_data(36'h0), .busy(w_busy), .ser_clk(w_clk), .ser_dat(w_dat), .ser_load(w_load)
  );

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit wrap_done = 1'b0;
  bit main_done = 1'b0;

  // receiver for the main instance: a bit is taken on each detected ser_clk rise
  logic [FW-1:0] rx = '0;
  int  rx_n = 0;
  int  gap = 0;
  int  gap_err = 0;
  logic prev_clk = 1'b0;
  always @(negedge clk) begin
    gap = gap + 1;
    if (ser_clk && !prev_clk) begin
      rx = {rx[FW-2:0], ser_dat};
      if (rx_n > 0 && gap != 2) gap_err = gap_err + 1;
      rx_n = rx_n + 1;
      gap = 0;
    end
    prev_clk = ser_clk;
  end

  // receiver for the one-pixel instance
  logic [59:0] w_rx = '0;
  logic w_prev = 1'b0;
  always @(negedge clk) begin
    if (w_clk && !w_prev) w_rx = {w_rx[58:0], w_dat};
    w_prev = w_clk;
  end

  task automatic chk(bit ok, string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] widen_tb(logic [7:0] c);
    return (12'(c) << 4) | 12'(c >> 4);
  endfunction

  function automatic logic [FW-1:0] exp_frame(int k, logic [191:0] p, logic [287:0] r, int cnt);
    logic [287:0] pay;
    logic [5:0]   code;
    logic [7:0]   c;
    case (k)
      0: code = 6'b000000;
      1: code = 6'b010101;
      2: code = 6'b101010;
      default: code = 6'b111111;
    endcase
    pay = '0;
    if (k == 0) begin
      for (int col = 0; col < 3; col++)
        for (int q = 7; q >= 0; q--) begin
          c = p[q*24 + col*8 +: 8];
          pay = {pay[275:0], widen_tb(c)};
        end
    end else pay = r;
    return {8'b11101000, code, 10'(cnt), pay};
  endfunction

  function automatic logic [191:0] rnd_px();
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [287:0] rnd_raw();
    logic [287:0] v;
    for (int i = 0; i < 9; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_frame(int k, logic [191:0] p, logic [287:0] r, string req, bit poke);
    logic [FW-1:0] exp;
    int waited;
    exp = exp_frame(k, p, r, exp_cnt);
    @(negedge clk);
    kind = 2'(k); px = p; raw = r; start = 1'b1;
    rx_n = 0; gap_err = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", FW'(busy), FW'(1));
    waited = 0;
    while (!ser_load && waited < 2000) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 101) begin
        start = 1'b1; kind = 2'(3 - k); px = ~p; raw = ~r;
      end else if (poke && waited == 102) start = 1'b0;
    end
    chk(!ser_clk, "R8", "ser_clk low at load", FW'(ser_clk), FW'(0));
    chk(rx_n == FW && gap_err == 0, "R7", "bit count / spacing", FW'(rx_n), FW'(FW));
    chk(rx == exp, req, "frame contents", rx, exp);
    @(negedge clk);
    chk(!ser_load && !busy, "R9", "load one cycle, busy drops", FW'({ser_load, busy}), FW'(0));
    exp_cnt = (exp_cnt + 1) % 1024;
  endtask

  initial begin : main
    logic [191:0] p;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk({ser_clk, ser_dat, ser_load, busy} == 4'b0, "R1", "outputs in reset",
        FW'({ser_clk, ser_dat, ser_load, busy}), FW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_clk, ser_dat, ser_load, busy} == 4'b0, "R1", "idle after reset",
        FW'({ser_clk, ser_dat, ser_load, busy}), FW'(0));
    // R1 first frame carries number 0; R2 header; R4 widening of all-ones
    run_frame(0, {192{1'b1}}, '0, "R1", 1'b0);
    run_frame(0, '0, {288{1'b1}}, "R4", 1'b0);
    // R5 distinct per-pixel pattern
    for (int i = 0; i < 8; i++) p[i*24 +: 24] = {4'h1, 4'(i), 4'h2, 4'(i), 4'h3, 4'(i)};
    run_frame(0, p, '0, "R5", 1'b0);
    // R3 / R6 each raw kind, px must not matter
    run_frame(1, rnd_px(), rnd_raw(), "R3", 1'b0);
    run_frame(2, rnd_px(), rnd_raw(), "R6", 1'b0);
    run_frame(3, rnd_px(), rnd_raw(), "R3", 1'b0);
    for (int i = 0; i < 6; i++) run_frame(0, rnd_px(), rnd_raw(), "R5", 1'b0);
    for (int i = 0; i < 3; i++) run_frame(1 + ($urandom % 3), rnd_px(), rnd_raw(), "R6", 1'b0);
    // R11 start mid-frame ignored
    run_frame(0, rnd_px(), rnd_raw(), "R11", 1'b1);
    rx_n = 0;
    repeat (6) @(negedge clk);
    chk(rx_n == 0 && !busy, "R11", "no second frame", FW'(rx_n), FW'(0));
    run_frame(2, rnd_px(), rnd_raw(), "R10", 1'b0);
    main_done = 1'b1;
  end

  initial begin : wrap_thread
    int bad;
    int got;
    bad = 0;
    @(posedge rst_n);
    for (int f = 0; f < 1026; f++) begin
      @(negedge clk); w_start = 1'b1;
      @(negedge clk); w_start = 1'b0;
      while (!w_load) @(negedge clk);
      got = int'(w_rx[45:36]);
      if (got != f % 1024 || w_rx[59:52] != 8'b11101000) bad++;
      if (f == 1023 || f == 1024)
        chk(got == f % 1024, "R10", "frame number near wrap", FW'(got), FW'(f % 1024));
    end
    chk(bad == 0, "R10", "frame numbers over 1026 frames", FW'(bad), FW'(0));
    wrap_done = 1'b1;
  end

  initial begin : finisher
    fork
      begin
        wait (main_done && wrap_done);
      end
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule